// File: doc/BRIEF.md
# Bus Tap and Injection Unit

This unit sits next to a simple processor's memory bus and acts on an extension word that a side control store delivers alongside every instruction fetch. The word is held for the whole instruction. Its opcode says which side effect the instruction carries: copying read data, store data, addresses or literals into a bank of output registers; replacing read or store data with a synchronized external input word; or loading a capture register, a serially read history register or a backup register. The host instruction itself runs unchanged and takes no extra cycles.

The bus is seen as one cycle type per clock: instruction fetch, data read or data write, each with a strobe. The first clock after a fetch is the "first execute cycle", and the one-shot side effects happen in it. Data-path injection goes through 2-to-1 multiplexers: the unit outputs the data the processor receives, the data memory receives and the memory write enable. No tri-state buses are used.

Top module: `ext_bus_tap`

## Requirements
- R1: Extension word layout is opcode in the top 4 bits, register select in the next log2(NOUT) bits, literal in the low DW bits. It is latched at the end of each fetch cycle and holds until the next fetch. Opcode 0 has no side effect, and so do the unused opcodes 14 and 15.
- R2: Opcode 1 writes the literal into output register `sel` at the end of the first execute cycle.
- R3: Opcode 2 copies the read data into output register `sel` at the end of every data-read cycle. Opcode 3 copies the store data at the end of every data-write cycle.
- R4: Opcode 4 buffers the instruction word read during the fetch cycle and writes it into output register `sel` at the end of the first execute cycle.
- R5: Opcode 5 copies the bus address (zero-extended) into output register `sel` on a data read. Opcode 6 does the same on a data write.
- R6: On a data write, opcode 7 puts the address into output register `sel` and the store data into register (`sel`+1) mod NOUT. It also holds the memory write enable low.
- R7: Opcode 8 feeds input register (`sel` mod NIN) to the processor in place of the read data. Opcode 9 feeds it to memory in place of the store data. Fetch cycles are never injected.
- R8: Each external input word passes a two-stage synchronizer. A change first reaches the data path two clock edges later.
- R9: Opcode 10 loads the capture register from input register (`sel` mod NIN) at the end of the first execute cycle.
- R10: Opcode 11 loads the history register with the address of the fetched instruction at the end of the first execute cycle. Each clock with the shift strobe high moves it one bit toward the LSB, and the serial output is its LSB. A load takes precedence over a shift.
- R11: Opcode 12 copies the working-register input into the backup register at the end of the first execute cycle. Opcode 13 raises the restore strobe during the first execute cycle while the backup value stays on its output.
- R12: A mode whose cycle type does not match the current bus cycle has no effect. One-shot modes act only in the first execute cycle. Data modes act on every matching access until the next fetch.
- R13: After reset, all output, capture, history and backup registers read zero, and the held opcode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_i | input | 1 | Current bus cycle is an instruction fetch |
| rd_i | input | 1 | Current bus cycle is a data read |
| wr_i | input | 1 | Current bus cycle is a data write |
| addr_i | input | AW | Bus address |
| mem_rdata_i | input | DW | Data read from memory |
| cpu_wdata_i | input | DW | Store data from the processor |
| ext_word_i | input | 4+log2(NOUT)+DW | Extension word from the side control store |
| ext_in_i | input | NIN*DW | Asynchronous external input words |
| wrk_i | input | DW | Working register value to back up |
| hist_shift_i | input | 1 | Shift strobe for serial history readout |
| cpu_rdata_o | output | DW | Data presented to the processor |
| mem_wdata_o | output | DW | Data presented to memory |
| mem_we_o | output | 1 | Memory write enable |
| out_regs_o | output | NOUT*DW | Output register bank, register i at bits i*DW |
| capture_o | output | DW | Capture register |
| hist_sout_o | output | 1 | Serial history output |
| bkp_o | output | DW | Backup register |
| wrk_restore_o | output | 1 | Restore strobe for the working register |

## Verification
The bench builds the unit with DW=8, AW=8, NOUT=4 and NIN=2. That keeps the extension word at 14 bits and makes a full sweep practical. For every one of the 16 opcodes and all four select values, it runs a fetch, a first-execute read, a write, a second read and an idle cycle. So each mode is met under every cycle type, and the wrap of the paired register from select 3 to 0 is reached. Directed runs then time the synchronizer edge by edge and shift the history register out bit by bit.

// File: rtl/xtap_pkg.sv
package xtap_pkg;
  localparam logic [3:0] OP_NONE    = 4'd0;
  localparam logic [3:0] OP_LIT     = 4'd1;
  localparam logic [3:0] OP_RD_DATA = 4'd2;
  localparam logic [3:0] OP_WR_DATA = 4'd3;
  localparam logic [3:0] OP_IMM     = 4'd4;
  localparam logic [3:0] OP_RD_ADDR = 4'd5;
  localparam logic [3:0] OP_WR_ADDR = 4'd6;
  localparam logic [3:0] OP_WR_BOTH = 4'd7;
  localparam logic [3:0] OP_IN_RD   = 4'd8;
  localparam logic [3:0] OP_IN_WR   = 4'd9;
  localparam logic [3:0] OP_CAPTURE = 4'd10;
  localparam logic [3:0] OP_TRACE   = 4'd11;
  localparam logic [3:0] OP_BACKUP  = 4'd12;
  localparam logic [3:0] OP_RECALL  = 4'd13;

  localparam logic [2:0] SRC_LIT   = 3'd0;
  localparam logic [2:0] SRC_RDATA = 3'd1;
  localparam logic [2:0] SRC_WDATA = 3'd2;
  localparam logic [2:0] SRC_IMM   = 3'd3;
  localparam logic [2:0] SRC_ADDR  = 3'd4;

  typedef struct packed {
    logic       a_we;
    logic [2:0] a_src;
    logic       b_we;
    logic       inj_rd;
    logic       inj_wr;
    logic       we_block;
    logic       cap_ld;
    logic       hist_ld;
    logic       bkp_ld;
    logic       recall;
  } ctl_t;
endpackage

// File: rtl/xtap_sync.sv
module xtap_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/xtap_decode.sv
module xtap_decode
  import xtap_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       fresh_i,
  input  logic       rd_i,
  input  logic       wr_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (op_i)
      OP_LIT:     begin ctl_o.a_we = fresh_i; ctl_o.a_src = SRC_LIT;   end
      OP_IMM:     begin ctl_o.a_we = fresh_i; ctl_o.a_src = SRC_IMM;   end
      OP_RD_DATA: begin ctl_o.a_we = rd_i;    ctl_o.a_src = SRC_RDATA; end
      OP_WR_DATA: begin ctl_o.a_we = wr_i;    ctl_o.a_src = SRC_WDATA; end
      OP_RD_ADDR: begin ctl_o.a_we = rd_i;    ctl_o.a_src = SRC_ADDR;  end
      OP_WR_ADDR: begin ctl_o.a_we = wr_i;    ctl_o.a_src = SRC_ADDR;  end
      OP_WR_BOTH: begin
        ctl_o.a_we     = wr_i;
        ctl_o.a_src    = SRC_ADDR;
        ctl_o.b_we     = wr_i;
        ctl_o.we_block = wr_i;
      end
      OP_IN_RD:   ctl_o.inj_rd  = rd_i;
      OP_IN_WR:   ctl_o.inj_wr  = wr_i;
      OP_CAPTURE: ctl_o.cap_ld  = fresh_i;
      OP_TRACE:   ctl_o.hist_ld = fresh_i;
      OP_BACKUP:  ctl_o.bkp_ld  = fresh_i;
      OP_RECALL:  ctl_o.recall  = fresh_i;
      default:    ;
    endcase
  end
endmodule

// File: rtl/xtap_outbank.sv
module xtap_outbank #(
  parameter int DW   = 16,
  parameter int NOUT = 4,
  parameter int SW   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_we_i,
  input  logic [SW-1:0]     a_sel_i,
  input  logic [DW-1:0]     a_d_i,
  input  logic              b_we_i,
  input  logic [SW-1:0]     b_sel_i,
  input  logic [DW-1:0]     b_d_i,
  output logic [NOUT*DW-1:0] q_o
);
  for (genvar g = 0; g < NOUT; g++) begin : g_reg
    logic          en;
    logic [DW-1:0] d_n, r_q;

    always_comb begin
      en  = 1'b0;
      d_n = r_q;
      if (a_we_i && a_sel_i == SW'(g)) begin
        en  = 1'b1;
        d_n = a_d_i;
      end else if (b_we_i && b_sel_i == SW'(g)) begin
        en  = 1'b1;
        d_n = b_d_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  r_q <= '0;
      else if (en)  r_q <= d_n;
    end

    assign q_o[g*DW +: DW] = r_q;
  end
endmodule

// File: rtl/ext_bus_tap.sv
module ext_bus_tap
  import xtap_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int NOUT = 4,
  parameter int NIN  = 2,
  localparam int SW  = $clog2(NOUT),
  localparam int IW  = $clog2(NIN),
  localparam int EW  = 4 + SW + DW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      mem_rdata_i,
  input  logic [DW-1:0]      cpu_wdata_i,
  input  logic [EW-1:0]      ext_word_i,
  input  logic [NIN*DW-1:0]  ext_in_i,
  input  logic [DW-1:0]      wrk_i,
  input  logic               hist_shift_i,
  output logic [DW-1:0]      cpu_rdata_o,
  output logic [DW-1:0]      mem_wdata_o,
  output logic               mem_we_o,
  output logic [NOUT*DW-1:0] out_regs_o,
  output logic [DW-1:0]      capture_o,
  output logic               hist_sout_o,
  output logic [DW-1:0]      bkp_o,
  output logic               wrk_restore_o
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  // held extension word and per-fetch buffers
  logic [EW-1:0] xdr_q;
  logic          fresh_q;
  logic [DW-1:0] imm_q;
  logic [AW-1:0] fa_q;
  logic [DW-1:0] cap_q, cap_d, bkp_q, bkp_d;
  logic [AW-1:0] hist_q, hist_d;
  logic          hist_en, hist_ld_w;

  logic [3:0]    op;
  logic [SW-1:0] sel, sel_b;
  logic [DW-1:0] lit, addr_ext, a_d, in_word;
  logic [NIN*DW-1:0] in_q;
  logic [IW-1:0] in_sel;
  ctl_t          ctl;

  assign op     = xdr_q[EW-1 -: 4];
  assign sel    = xdr_q[DW +: SW];
  assign lit    = xdr_q[DW-1:0];
  assign sel_b  = sel + SW'(1);
  assign in_sel = sel[IW-1:0];

  xtap_sync #(.W(NIN*DW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_q),
    .d_i   (ext_in_i),
    .q_o   (in_q)
  );

  xtap_decode u_dec (
    .op_i   (op),
    .fresh_i(fresh_q),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .ctl_o  (ctl)
  );

  always_comb begin
    addr_ext           = '0;
    addr_ext[AW-1:0]   = addr_i;
    in_word            = in_q[in_sel*DW +: DW];
    case (ctl.a_src)
      SRC_LIT:   a_d = lit;
      SRC_RDATA: a_d = mem_rdata_i;
      SRC_WDATA: a_d = cpu_wdata_i;
      SRC_IMM:   a_d = imm_q;
      default:   a_d = addr_ext;
    endcase
  end

  xtap_outbank #(.DW(DW), .NOUT(NOUT), .SW(SW)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_q),
    .a_we_i (ctl.a_we),
    .a_sel_i(sel),
    .a_d_i  (a_d),
    .b_we_i (ctl.b_we),
    .b_sel_i(sel_b),
    .b_d_i  (cpu_wdata_i),
    .q_o    (out_regs_o)
  );

  // next state of the one-shot registers
  assign hist_ld_w = ctl.hist_ld;
  always_comb begin
    cap_d   = ctl.cap_ld ? in_word : cap_q;
    bkp_d   = ctl.bkp_ld ? wrk_i : bkp_q;
    hist_en = ctl.hist_ld | hist_shift_i;
    if (ctl.hist_ld)      hist_d = fa_q;
    else if (hist_shift_i) hist_d = hist_q >> 1;
    else                  hist_d = hist_q;
  end

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      xdr_q   <= '0;
      fresh_q <= 1'b0;
      imm_q   <= '0;
      fa_q    <= '0;
      cap_q   <= '0;
      bkp_q   <= '0;
      hist_q  <= '0;
    end else begin
      fresh_q <= fetch_i;
      if (fetch_i) begin
        xdr_q <= ext_word_i;
        imm_q <= mem_rdata_i;
        fa_q  <= addr_i;
      end
      if (ctl.cap_ld) cap_q  <= cap_d;
      if (ctl.bkp_ld) bkp_q  <= bkp_d;
      if (hist_en)    hist_q <= hist_d;
    end
  end

  // data-path multiplexers
  assign cpu_rdata_o   = ctl.inj_rd ? in_word : mem_rdata_i;
  assign mem_wdata_o   = ctl.inj_wr ? in_word : cpu_wdata_i;
  assign mem_we_o      = wr_i & ~ctl.we_block;
  assign capture_o     = cap_q;
  assign bkp_o         = bkp_q;
  assign hist_sout_o   = hist_q[0];
  assign wrk_restore_o = ctl.recall;
endmodule

// File: rtl/xtap_chk.sv
module xtap_chk #(
  parameter int DW   = 16,
  parameter int NOUT = 4
) (
  input logic               clk,
  input logic               rst_q,
  input logic               fetch,
  input logic               rd,
  input logic               wr,
  input logic               mem_we,
  input logic [DW-1:0]      cpu_rdata,
  input logic [DW-1:0]      mem_rdata,
  input logic [NOUT*DW-1:0] outs,
  input logic               fresh,
  input logic               recall,
  input logic               hist_shift,
  input logic               hist_ld,
  input logic               hist_b1,
  input logic               hist_sout
);
  p_fetch_clean_r7: assert property (@(posedge clk) disable iff (!rst_q)
    fetch |-> cpu_rdata == mem_rdata);

  p_we_gate_r6: assert property (@(posedge clk) disable iff (!rst_q)
    mem_we |-> wr);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_q)
    (!rd && !wr && !fresh) |=> $stable(outs));

  p_cycle_type_r12: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({fetch, rd, wr}));

  p_recall_first_r11: assert property (@(posedge clk) disable iff (!rst_q)
    recall |-> fresh);

  p_shift_out_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (hist_shift && !hist_ld) |=> hist_sout == $past(hist_b1));
endmodule

bind ext_bus_tap xtap_chk #(.DW(DW), .NOUT(NOUT)) u_chk (
  .clk       (clk_i),
  .rst_q     (rst_q),
  .fetch     (fetch_i),
  .rd        (rd_i),
  .wr        (wr_i),
  .mem_we    (mem_we_o),
  .cpu_rdata (cpu_rdata_o),
  .mem_rdata (mem_rdata_i),
  .outs      (out_regs_o),
  .fresh     (fresh_q),
  .recall    (wrk_restore_o),
  .hist_shift(hist_shift_i),
  .hist_ld   (hist_ld_w),
  .hist_b1   (hist_q[1]),
  .hist_sout (hist_sout_o)
);

// File: tb/test_ext_bus_tap.sv
`timescale 1ns/1ps
module test_ext_bus_tap;
  localparam int DW = 8, AW = 8, NOUT = 4, NIN = 2, EW = 14;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, fetch, rd, wr, hist_shift;
  logic [AW-1:0] addr;
  logic [DW-1:0] mem_rdata, cpu_wdata, wrk;
  logic [EW-1:0] ext_word;
  logic [NIN*DW-1:0] ext_in;
  logic [DW-1:0] cpu_rdata, mem_wdata, capture, bkp;
  logic mem_we, hist_sout, wrk_restore;
  logic [NOUT*DW-1:0] out_regs;

  ext_bus_tap #(.DW(DW), .AW(AW), .NOUT(NOUT), .NIN(NIN)) i_ext_bus_tap (
    .clk_i(clk), .rst_ni(rst_n), .fetch_i(fetch), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .mem_rdata_i(mem_rdata), .cpu_wdata_i(cpu_wdata),
    .ext_word_i(ext_word), .ext_in_i(ext_in), .wrk_i(wrk),
    .hist_shift_i(hist_shift), .cpu_rdata_o(cpu_rdata), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .out_regs_o(out_regs), .capture_o(capture),
    .hist_sout_o(hist_sout), .bkp_o(bkp), .wrk_restore_o(wrk_restore));

  int total = 0, bad = 0;
  logic [DW-1:0] m_out [NOUT];
  logic [DW-1:0] m_cap, m_bkp;
  logic [DW-1:0] inv [NIN];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    for (int i = 0; i < NOUT; i++) chk(tag, 16'(out_regs[i*DW +: DW]), 16'(m_out[i]));
    chk({tag, "/R9"}, 16'(capture), 16'(m_cap));
    chk({tag, "/R11"}, 16'(bkp), 16'(m_bkp));
  endtask

  task automatic drive(input logic f, input logic r, input logic w,
                       input logic [7:0] a, input logic [7:0] rdat, input logic [7:0] wdat);
    @(negedge clk);
    fetch = f; rd = r; wr = w; addr = a; mem_rdata = rdat; cpu_wdata = wdat;
    #2;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fetch = 0; rd = 0; wr = 0; hist_shift = 0;
    addr = '0; mem_rdata = '0; cpu_wdata = '0; wrk = '0; ext_word = '0;
    inv[0] = 8'h27; inv[1] = 8'h9D;
    ext_in = {inv[1], inv[0]};
    for (int i = 0; i < NOUT; i++) m_out[i] = '0;
    m_cap = '0; m_bkp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk_state("R13 reset");
    chk("R13 hist", 16'(hist_sout), 16'h0);
    chk("R13 restore", 16'(wrk_restore), 16'h0);

    // full sweep: every opcode and select under each cycle type
    for (int op = 0; op < 16; op++) begin
      for (int s = 0; s < NOUT; s++) begin
        logic [7:0] lit, ins, fa, ra, rdv, wa, wdv, ra2, rd2;
        lit = 8'(op * 16 + s * 4 + 1);
        ins = 8'hA0 ^ lit;  fa  = 8'(op * 4 + s);
        ra  = 8'h40 + lit;  rdv = 8'h5A ^ lit;
        wa  = 8'h80 + lit;  wdv = 8'hC3 ^ lit;
        ra2 = 8'h11 + lit;  rd2 = 8'h66 ^ lit;
        ext_word = {4'(op), 2'(s), lit};
        wrk = 8'h3C ^ lit;

        drive(1, 0, 0, fa, ins, 8'h00);
        chk("R7 fetch pass", 16'(cpu_rdata), 16'(ins));
        @(posedge clk);
        @(negedge clk);
        chk_state("R1 after fetch");

        // first execute cycle is a data read
        drive(0, 1, 0, ra, rdv, 8'h00);
        chk("R7 rd mux", 16'(cpu_rdata), 16'(op == 8 ? inv[s % NIN] : rdv));
        chk("R11 restore strobe", 16'(wrk_restore), 16'(op == 13));
        chk("R6 no we on rd", 16'(mem_we), 16'h0);
        @(posedge clk);
        case (op)
          1:  m_out[s] = lit;
          2:  m_out[s] = rdv;
          4:  m_out[s] = ins;
          5:  m_out[s] = ra;
          10: m_cap = inv[s % NIN];
          12: m_bkp = 8'h3C ^ lit;
          default: ;
        endcase
        @(negedge clk);
        chk_state("R2/R3/R4/R5/R12 first cycle");
        if (op == 11) chk("R10 load", 16'(hist_sout), 16'(fa[0]));

        drive(0, 0, 1, wa, 8'h00, wdv);
        chk("R6 we", 16'(mem_we), 16'(op != 7));
        chk("R7 wr mux", 16'(mem_wdata), 16'(op == 9 ? inv[s % NIN] : wdv));
        chk("R11 restore once", 16'(wrk_restore), 16'h0);
        @(posedge clk);
        case (op)
          3: m_out[s] = wdv;
          6: m_out[s] = wa;
          7: begin m_out[s] = wa; m_out[(s + 1) % NOUT] = wdv; end
          default: ;
        endcase
        @(negedge clk);
        chk_state("R3/R5/R6/R12 write");

        // second read: data modes persist, one-shots do not repeat
        drive(0, 1, 0, ra2, rd2, 8'h00);
        chk("R7 rd again", 16'(cpu_rdata), 16'(op == 8 ? inv[s % NIN] : rd2));
        @(posedge clk);
        if (op == 2) m_out[s] = rd2;
        if (op == 5) m_out[s] = ra2;
        @(negedge clk);
        chk_state("R12 second read");

        drive(0, 0, 0, 8'h00, 8'h00, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk_state("R1/R12 idle");
      end
    end

    // synchronizer latency
    ext_word = {4'd8, 2'd0, 8'h00};
    drive(1, 0, 0, 8'h01, 8'h00, 8'h00);
    @(posedge clk);
    @(negedge clk);
    fetch = 0; rd = 1; ext_in = {inv[1], 8'h55};
    #2 chk("R8 edge0", 16'(cpu_rdata), 16'h27);
    @(posedge clk);
    @(negedge clk);
    #2 chk("R8 edge1", 16'(cpu_rdata), 16'h27);
    @(posedge clk);
    @(negedge clk);
    #2 chk("R8 edge2", 16'(cpu_rdata), 16'h55);
    drive(0, 0, 0, 8'h00, 8'h00, 8'h00);

    // history serial readout
    ext_word = {4'd11, 2'd0, 8'h00};
    drive(1, 0, 0, 8'hB6, 8'h00, 8'h00);
    @(posedge clk);
    drive(0, 0, 0, 8'h00, 8'h00, 8'h00);
    @(posedge clk);
    for (int b = 0; b < AW; b++) begin
      @(negedge clk);
      chk("R10 serial", 16'(hist_sout), 16'((8'hB6 >> b) & 8'h01));
      hist_shift = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    hist_shift = 1'b0;
    chk("R10 drained", 16'(hist_sout), 16'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule